// File: doc/BRIEF.md
# Ethernet MAC control/status register and interrupt unit

This block is the software-visible front end of a descriptor-based Ethernet MAC. It decodes single-cycle register writes and combinational reads from a simple bus. It holds the control word, the event mask, the management frame and speed words, the transmit control word and the two ring base addresses. It also keeps the current receive and transmit descriptor pointers, which the DMA engines advance through dedicated update ports.

Writes to the two kick offsets produce one-cycle strobes for the receive and transmit engines. Some register writes have side effects. A control write with the soft-reset bit returns every register to its power-on value. A control write with the enable bit clear stops receive and rewinds both descriptor pointers to their ring bases. A management frame write and a graceful-stop request each post their completion event at once. Engine-reported events and these side-effect events all accumulate in one sticky event register. The interrupt line is high whenever an unmasked event is pending.

Top module: `emac_csr_irq`

## Requirements
- R1: After reset every mapped register reads zero, `irq_o`, `rx_active_o`, `tx_kick_o` and `rx_kick_o` are low, and both pointers are zero.
- R2: The event register at offset 0x004 implements only bits 31 down to 19; the other bits always read zero. Writing a one to an implemented bit clears it. A set from `evt_set_i` or from a register side effect wins over a clear in the same cycle. Set bits stay set until they are cleared.
- R3: `irq_o` is high exactly when the event register and the mask register (offset 0x008) share at least one set bit.
- R4: A write to offset 0x014 pulses `tx_kick_o` for one cycle, starting in the cycle after the write, only while control bit 1 (enable) is set.
- R5: A write to offset 0x010 pulses `rx_kick_o` for one cycle in the cycle after the write, and sets `rx_active_o`. It does so only while enable is set and `rx_active_o` is low; otherwise it has no effect.
- R6: A write to the control register (offset 0x024) with bit 0 set is a soft reset. Every register, the event register, `rx_active_o` and both pointers return to their reset values, and the written value is not kept.
- R7: A control write with bit 1 clear drops `rx_active_o`. It also loads the receive pointer from the receive ring base (offset 0x100) and the transmit pointer from the transmit ring base (offset 0x104).
- R8: A write to the management frame register (offset 0x040) stores the value and sets event bit 23 in the next cycle.
- R9: The management speed register (offset 0x044) keeps only the written value ANDed with 0x000000FE.
- R10: A write to the transmit control register (offset 0x0C4) stores the value. If bit 0 of the value is set, event bit 28 is set in the next cycle; if bit 0 is clear, the event register is left unchanged.
- R11: Unmapped offsets and the two kick offsets read as zero.
- R12: An update strobe on `tx_ptr_upd_i` or `rx_ptr_upd_i` loads the matching pointer output with the supplied value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus access valid |
| req_write_i | input | 1 | Access is a write |
| req_addr_i | input | ADDR_W | Byte offset |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data for `req_addr_i` (combinational) |
| evt_set_i | input | 32 | Engine event set bits |
| tx_ptr_upd_i | input | 1 | Transmit engine pointer update strobe |
| tx_ptr_val_i | input | PTR_W | New transmit pointer |
| rx_ptr_upd_i | input | 1 | Receive engine pointer update strobe |
| rx_ptr_val_i | input | PTR_W | New receive pointer |
| tx_kick_o | output | 1 | Transmit start strobe |
| rx_kick_o | output | 1 | Receive start strobe |
| rx_active_o | output | 1 | Receive enabled |
| tx_ptr_o | output | PTR_W | Current transmit descriptor pointer |
| rx_ptr_o | output | PTR_W | Current receive descriptor pointer |
| irq_o | output | 1 | Interrupt request |

## Verification
Each kick is tried with the block disabled and then enabled. The receive kick is also repeated while receive is already active; this separates the enable gate from the already-active gate. Events are raised by the engine port and by each side-effect write. A set and a clear of the same bit in one cycle shows whether set has priority. An all-ones set shows which bits are implemented. A control write with enable clear is compared with one carrying the soft-reset bit: the first must rewind the pointers to the programmed bases, the second must zero everything.

// File: rtl/emac_csr_pkg.sv
package emac_csr_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned OFS_EVT    = 'h004;
  localparam int unsigned OFS_MASK   = 'h008;
  localparam int unsigned OFS_RXGO   = 'h010;
  localparam int unsigned OFS_TXGO   = 'h014;
  localparam int unsigned OFS_CTRL   = 'h024;
  localparam int unsigned OFS_MGMT   = 'h040;
  localparam int unsigned OFS_SPD    = 'h044;
  localparam int unsigned OFS_TXCTL  = 'h0C4;
  localparam int unsigned OFS_RXBASE = 'h100;
  localparam int unsigned OFS_TXBASE = 'h104;

  localparam int unsigned CTRL_RST_BIT = 0;
  localparam int unsigned CTRL_EN_BIT  = 1;
  localparam int unsigned EVT_MGMT_BIT = 23;
  localparam int unsigned EVT_GRA_BIT  = 28;

  localparam logic [DW-1:0] EVT_IMPL = 32'hFFF8_0000;
  localparam logic [DW-1:0] SPD_KEEP = 32'h0000_00FE;

  typedef struct packed {
    logic evt;
    logic mask;
    logic rxgo;
    logic txgo;
    logic ctrl;
    logic mgmt;
    logic spd;
    logic txctl;
    logic rxbase;
    logic txbase;
  } csr_sel_t;
endpackage

// File: rtl/emac_csr_dec.sv
module emac_csr_dec
  import emac_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output csr_sel_t          sel_o
);
  always_comb begin
    sel_o        = '0;
    sel_o.evt    = (addr_i == ADDR_W'(OFS_EVT));
    sel_o.mask   = (addr_i == ADDR_W'(OFS_MASK));
    sel_o.rxgo   = (addr_i == ADDR_W'(OFS_RXGO));
    sel_o.txgo   = (addr_i == ADDR_W'(OFS_TXGO));
    sel_o.ctrl   = (addr_i == ADDR_W'(OFS_CTRL));
    sel_o.mgmt   = (addr_i == ADDR_W'(OFS_MGMT));
    sel_o.spd    = (addr_i == ADDR_W'(OFS_SPD));
    sel_o.txctl  = (addr_i == ADDR_W'(OFS_TXCTL));
    sel_o.rxbase = (addr_i == ADDR_W'(OFS_RXBASE));
    sel_o.txbase = (addr_i == ADDR_W'(OFS_TXBASE));
  end
endmodule

// File: rtl/emac_evt_reg.sv
module emac_evt_reg
  import emac_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_clr_i,
  input  logic [DW-1:0] w1c_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] evt_o
);
  logic [DW-1:0] evt_q;

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         evt_q <= '0;
    else if (soft_clr_i) evt_q <= '0;
    else                 evt_q <= ((evt_q & ~w1c_i) | set_i) & EVT_IMPL;
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/emac_ptr_trk.sv
module emac_ptr_trk #(
  parameter int unsigned PTR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_clr_i,
  input  logic             rewind_i,
  input  logic [PTR_W-1:0] base_i,
  input  logic             upd_i,
  input  logic [PTR_W-1:0] upd_val_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (soft_clr_i) ptr_q <= '0;
    else if (rewind_i)   ptr_q <= base_i;
    else if (upd_i)      ptr_q <= upd_val_i;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/emac_csr_irq.sv
module emac_csr_irq
  import emac_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PTR_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic [DW-1:0]     rsp_rdata_o,
  input  logic [DW-1:0]     evt_set_i,
  input  logic              tx_ptr_upd_i,
  input  logic [PTR_W-1:0]  tx_ptr_val_i,
  input  logic              rx_ptr_upd_i,
  input  logic [PTR_W-1:0]  rx_ptr_val_i,
  output logic              tx_kick_o,
  output logic              rx_kick_o,
  output logic              rx_active_o,
  output logic [PTR_W-1:0]  tx_ptr_o,
  output logic [PTR_W-1:0]  rx_ptr_o,
  output logic              irq_o
);
  localparam int unsigned NRING  = 2;  // 0: receive, 1: transmit
  localparam int unsigned CTRL_W = CTRL_EN_BIT + 1;

  csr_sel_t sel;
  logic wr, soft_rst, dis_wr, rx_fire, tx_fire;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0] mask_q, mgmt_q, spd_q, txctl_q, evt_q, evt_set, evt_w1c;
  logic [PTR_W-1:0] rxbase_q, txbase_q;
  logic rx_active_q, tx_kick_q, rx_kick_q;
  logic [PTR_W-1:0] ring_base [NRING];
  logic             ring_upd  [NRING];
  logic [PTR_W-1:0] ring_val  [NRING];
  logic [PTR_W-1:0] ring_ptr  [NRING];

  emac_csr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr_i(req_addr_i), .sel_o(sel));

  assign wr       = req_valid_i & req_write_i;
  assign soft_rst = wr & sel.ctrl & req_wdata_i[CTRL_RST_BIT];
  assign dis_wr   = wr & sel.ctrl & ~req_wdata_i[CTRL_EN_BIT];
  assign rx_fire  = wr & sel.rxgo & ctrl_q[CTRL_EN_BIT] & ~rx_active_q;
  assign tx_fire  = wr & sel.txgo & ctrl_q[CTRL_EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      mask_q   <= '0;
      mgmt_q   <= '0;
      spd_q    <= '0;
      txctl_q  <= '0;
      rxbase_q <= '0;
      txbase_q <= '0;
    end else if (soft_rst) begin
      ctrl_q   <= '0;
      mask_q   <= '0;
      mgmt_q   <= '0;
      spd_q    <= '0;
      txctl_q  <= '0;
      rxbase_q <= '0;
      txbase_q <= '0;
    end else if (wr) begin
      if (sel.ctrl)   ctrl_q   <= req_wdata_i[CTRL_W-1:0];
      if (sel.mask)   mask_q   <= req_wdata_i;
      if (sel.mgmt)   mgmt_q   <= req_wdata_i;
      if (sel.spd)    spd_q    <= req_wdata_i & SPD_KEEP;
      if (sel.txctl)  txctl_q  <= req_wdata_i;
      if (sel.rxbase) rxbase_q <= PTR_W'(req_wdata_i);
      if (sel.txbase) txbase_q <= PTR_W'(req_wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_active_q <= 1'b0;
      tx_kick_q   <= 1'b0;
      rx_kick_q   <= 1'b0;
    end else begin
      tx_kick_q <= tx_fire;
      rx_kick_q <= rx_fire;
      if (soft_rst || dis_wr) rx_active_q <= 1'b0;
      else if (rx_fire)       rx_active_q <= 1'b1;
    end
  end

  always_comb begin
    evt_w1c = (wr && sel.evt) ? req_wdata_i : '0;
    evt_set = evt_set_i;
    evt_set[EVT_MGMT_BIT] = evt_set_i[EVT_MGMT_BIT] | (wr & sel.mgmt);
    evt_set[EVT_GRA_BIT]  = evt_set_i[EVT_GRA_BIT] | (wr & sel.txctl & req_wdata_i[0]);
  end

  emac_evt_reg u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_clr_i(soft_rst),
    .w1c_i(evt_w1c), .set_i(evt_set), .evt_o(evt_q)
  );

  assign ring_base[0] = rxbase_q;
  assign ring_base[1] = txbase_q;
  assign ring_upd[0]  = rx_ptr_upd_i;
  assign ring_upd[1]  = tx_ptr_upd_i;
  assign ring_val[0]  = rx_ptr_val_i;
  assign ring_val[1]  = tx_ptr_val_i;

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    emac_ptr_trk #(.PTR_W(PTR_W)) u_trk (
      .clk_i(clk_i), .rst_ni(rst_ni), .soft_clr_i(soft_rst),
      .rewind_i(dis_wr), .base_i(ring_base[g]),
      .upd_i(ring_upd[g]), .upd_val_i(ring_val[g]), .ptr_o(ring_ptr[g])
    );
  end

  always_comb begin
    rsp_rdata_o = '0;
    if (sel.evt)    rsp_rdata_o = evt_q;
    if (sel.mask)   rsp_rdata_o = mask_q;
    if (sel.ctrl)   rsp_rdata_o = DW'(ctrl_q);
    if (sel.mgmt)   rsp_rdata_o = mgmt_q;
    if (sel.spd)    rsp_rdata_o = spd_q;
    if (sel.txctl)  rsp_rdata_o = txctl_q;
    if (sel.rxbase) rsp_rdata_o = DW'(rxbase_q);
    if (sel.txbase) rsp_rdata_o = DW'(txbase_q);
  end

  assign rx_ptr_o    = ring_ptr[0];
  assign tx_ptr_o    = ring_ptr[1];
  assign rx_active_o = rx_active_q;
  assign tx_kick_o   = tx_kick_q;
  assign rx_kick_o   = rx_kick_q;
  assign irq_o       = |(evt_q & mask_q);
endmodule

// File: rtl/emac_csr_irq_chk.sv
module emac_csr_irq_chk
  import emac_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DW-1:0]     req_wdata_i,
  input logic [DW-1:0]     evt_q,
  input logic [DW-1:0]     mask_q,
  input logic              tx_kick_o,
  input logic              rx_kick_o,
  input logic              rx_active_o,
  input logic              irq_o
);
  logic wr;
  assign wr = req_valid_i && req_write_i;

  p_unimpl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q[18:0] == '0);

  p_mask_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);

  p_tx_kick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_kick_o |-> $past(wr && req_addr_i == ADDR_W'(OFS_TXGO)));

  p_rx_kick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_kick_o |-> (rx_active_o && !$past(rx_active_o)));

  p_soft_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_addr_i == ADDR_W'(OFS_CTRL) && req_wdata_i[CTRL_RST_BIT])
      |=> (evt_q == '0 && mask_q == '0 && !rx_active_o));

  p_disable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_addr_i == ADDR_W'(OFS_CTRL) && !req_wdata_i[CTRL_EN_BIT])
      |=> !rx_active_o);

  p_mgmt_evt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_addr_i == ADDR_W'(OFS_MGMT)) |=> evt_q[EVT_MGMT_BIT]);

  p_gra_evt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_addr_i == ADDR_W'(OFS_TXCTL) && req_wdata_i[0]) |=> evt_q[EVT_GRA_BIT]);
endmodule

bind emac_csr_irq emac_csr_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
  .evt_q(evt_q), .mask_q(mask_q), .tx_kick_o(tx_kick_o), .rx_kick_o(rx_kick_o),
  .rx_active_o(rx_active_o), .irq_o(irq_o)
);

// File: tb/sim_emac_csr_irq.sv
module sim_emac_csr_irq;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned PTR_W  = 32;

  localparam int S_RD = 0, S_IRQ = 1, S_TXK = 2, S_RXK = 3, S_RXA = 4, S_TXP = 5, S_RXP = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0, evt_set_i = '0, rsp_rdata_o;
  logic tx_ptr_upd_i = 1'b0, rx_ptr_upd_i = 1'b0;
  logic [PTR_W-1:0] tx_ptr_val_i = '0, rx_ptr_val_i = '0, tx_ptr_o, rx_ptr_o;
  logic tx_kick_o, rx_kick_o, rx_active_o, irq_o;

  always #2.5 clk = ~clk;

  emac_csr_irq #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .rsp_rdata_o(rsp_rdata_o),
    .evt_set_i(evt_set_i), .tx_ptr_upd_i(tx_ptr_upd_i), .tx_ptr_val_i(tx_ptr_val_i),
    .rx_ptr_upd_i(rx_ptr_upd_i), .rx_ptr_val_i(rx_ptr_val_i), .tx_kick_o(tx_kick_o),
    .rx_kick_o(rx_kick_o), .rx_active_o(rx_active_o), .tx_ptr_o(tx_ptr_o),
    .rx_ptr_o(rx_ptr_o), .irq_o(irq_o)
  );

  typedef struct { int sel; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  event mon_ev;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [31:0] obs(int s);
    case (s)
      S_RD:    return rsp_rdata_o;
      S_IRQ:   return {31'b0, irq_o};
      S_TXK:   return {31'b0, tx_kick_o};
      S_RXK:   return {31'b0, rx_kick_o};
      S_RXA:   return {31'b0, rx_active_o};
      S_TXP:   return tx_ptr_o;
      default: return rx_ptr_o;
    endcase
  endfunction

  // monitor: pops expected items and compares
  initial forever begin
    @(mon_ev);
    #0.1;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_vec++;
      if (obs(it.sel) !== it.exp) begin
        n_bad++;
        $display("FAIL %s act=%h exp=%h", it.tag, obs(it.sel), it.exp);
      end
    end
  end

  task automatic chk(int s, logic [31:0] e, string t);
    sb.push_back('{s, e, t});
    ->mon_ev;
    #0.2;
  endtask

  task automatic chk_rd(int a, logic [31:0] e, string t);
    req_addr_i = ADDR_W'(a);
    chk(S_RD, e, t);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1;
    req_addr_i = ADDR_W'(a); req_wdata_i = d;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk_rd('h024, 32'h0, "R1 ctrl");
    chk_rd('h004, 32'h0, "R1 event");
    chk_rd('h008, 32'h0, "R1 mask");
    chk(S_IRQ, 0, "R1 irq");
    chk(S_RXA, 0, "R1 rx_active");
    chk(S_TXP, 0, "R1 tx_ptr");
    // R11 unmapped and kick offsets
    chk_rd('h0FC, 32'h0, "R11 unmapped");
    chk_rd('h010, 32'h0, "R11 rx kick offset");
    chk_rd('h014, 32'h0, "R11 tx kick offset");
    // R4 tx kick
    wr('h014, 0);            chk(S_TXK, 0, "R4 kick while disabled");
    wr('h024, 32'h2);        chk_rd('h024, 32'h2, "R4 enable stored");
    wr('h014, 0);            chk(S_TXK, 1, "R4 kick pulse");
    idle();                  chk(S_TXK, 0, "R4 kick one cycle");
    // R5 rx kick
    wr('h010, 0);            chk(S_RXK, 1, "R5 rx kick pulse"); chk(S_RXA, 1, "R5 rx active");
    idle();                  chk(S_RXK, 0, "R5 rx kick one cycle");
    wr('h010, 0);            chk(S_RXK, 0, "R5 no kick when active");
    // R12 pointer updates
    @(negedge clk);
    tx_ptr_upd_i = 1'b1; tx_ptr_val_i = 32'h1234;
    rx_ptr_upd_i = 1'b1; rx_ptr_val_i = 32'h5678;
    @(negedge clk);
    tx_ptr_upd_i = 1'b0; rx_ptr_upd_i = 1'b0;
    chk(S_TXP, 32'h1234, "R12 tx ptr"); chk(S_RXP, 32'h5678, "R12 rx ptr");
    // R7 disable rewinds
    wr('h100, 32'hA000); wr('h104, 32'hB000);
    wr('h024, 32'h0);
    chk(S_RXA, 0, "R7 rx stopped");
    chk(S_RXP, 32'hA000, "R7 rx rewind"); chk(S_TXP, 32'hB000, "R7 tx rewind");
    chk_rd('h100, 32'hA000, "R7 rx base kept");
    wr('h014, 0);            chk(S_TXK, 0, "R4 kick after disable");
    // R8 management write
    wr('h040, 32'h5A5A);
    chk_rd('h040, 32'h5A5A, "R8 mgmt stored");
    chk_rd('h004, 32'h0080_0000, "R8 mgmt event");
    chk(S_IRQ, 0, "R3 masked off");
    // R3 mask and R2 W1C
    wr('h008, 32'h0080_0000); chk(S_IRQ, 1, "R3 irq on");
    wr('h004, 32'h0080_0000); chk_rd('h004, 32'h0, "R2 w1c"); chk(S_IRQ, 0, "R3 irq off");
    // R10 graceful stop
    wr('h0C4, 32'h1);        chk_rd('h004, 32'h1000_0000, "R10 gra event");
    chk(S_IRQ, 0, "R3 other bit masked");
    wr('h004, 32'hFFFF_FFFF);
    wr('h0C4, 32'h4);        chk_rd('h004, 32'h0, "R10 no event bit0 clear");
    chk_rd('h0C4, 32'h4, "R10 stored");
    // R9 speed mask
    wr('h044, 32'hFFFF_FFFF); chk_rd('h044, 32'hFE, "R9 speed");
    // R2 engine events and priority
    @(negedge clk); evt_set_i = 32'hFFFF_FFFF;
    @(negedge clk); evt_set_i = 32'h0;
    chk_rd('h004, 32'hFFF8_0000, "R2 implemented bits");
    chk(S_IRQ, 1, "R3 engine event unmasked");
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = ADDR_W'('h004);
    req_wdata_i = 32'h0400_0000; evt_set_i = 32'h0400_0000;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0; evt_set_i = 32'h0;
    chk_rd('h004, 32'hFFF8_0000, "R2 set beats clear");
    wr('h004, 32'h0400_0000); chk_rd('h004, 32'hFBF8_0000, "R2 plain clear");
    // R6 soft reset
    wr('h024, 32'h2); wr('h010, 0);
    chk(S_RXA, 1, "R6 precondition");
    wr('h024, 32'h3);
    chk_rd('h024, 32'h0, "R6 ctrl");
    chk_rd('h008, 32'h0, "R6 mask");
    chk_rd('h004, 32'h0, "R6 event");
    chk_rd('h044, 32'h0, "R6 speed");
    chk_rd('h100, 32'h0, "R6 ring base");
    chk(S_RXA, 0, "R6 rx active");
    chk(S_RXP, 0, "R6 rx ptr");
    chk(S_IRQ, 0, "R6 irq");
    wr('h010, 0);            chk(S_RXK, 0, "R5 kick while disabled"); chk(S_RXA, 0, "R5 stays idle");
    idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule